// File: doc/BRIEF.md
# Mode Register and Burst Column Sequencer

This block keeps the operating mode of a double-data-rate memory device and, for every read or write, produces the column addresses that the burst visits. The mode word arrives on the address bus with a mode-set strobe. It selects the burst length (2, 4 or 8), the wrap order (sequential or interleaved) and the CAS latency (2 or 2.5 clocks). Fields carrying a reserved code cause the whole word to be dropped, so the old mode stays in force.

Data moves on both clock edges, so a burst of length BL takes BL/2 clock cycles. The sequencer presents two columns per cycle: the even beat and the odd beat. A burst-start pulse loads the starting column and takes a snapshot of the current mode. A burst-stop pulse ends the burst early. For reads, a valid window follows the column beats two clocks later. When the latency is 2.5, a half-cycle flag is raised with it; the fractional timing itself is not produced here.

Top module: `burst_seq_top`

## Requirements
- R1: After reset the mode is burst length 2, sequential order and latency 2. `beat_valid`, `last_beat`, `rd_valid` and `rd_half` are all 0.
- R2: A `mode_set` pulse loads the mode from `mode_addr`, and the new mode is visible after that clock edge.
  - Bits 2:0 give the burst length: 001 means 2, 010 means 4, 011 means 8.
  - Bit 3 gives the order: 0 means sequential, 1 means interleaved.
  - Bits 6:4 give the latency: 010 means 2, 110 means 2.5.
  - Any other code in the length field or the latency field leaves all three mode outputs unchanged.
- R3: After the edge that samples `burst_start`, `beat_valid` stays high for exactly BL/2 cycles if the burst is not interrupted. `last_beat` is high only in the final cycle.
- R4: In sequential order, beat j carries column `(start low bits + j) mod BL` in its low log2(BL) bits. `col_even` carries beat 2i and `col_odd` carries beat 2i+1 in cycle i.
- R5: In interleaved order, the low log2(BL) bits of beat j are the starting low bits XOR j. In both orders, the column bits above log2(BL) keep their starting value for the whole burst.
- R6: If `burst_stop` is sampled during a burst with no `burst_start` on the same edge, `beat_valid` is 0 from the next cycle on.
- R7: A `burst_start` during a burst restarts the sequence from the new column at beat 0. `burst_start` wins over `burst_stop` when both arrive on the same edge.
- R8: `rd_valid` repeats, two cycles later, every cycle in which `beat_valid` was high for a read burst (`burst_is_read` = 1 at start). It stays low for write bursts, and a stopped burst shortens it by the same amount.
- R9: `rd_half` is high exactly when `rd_valid` is high and the burst was started while the latency was 2.5.
- R10: A burst uses the length and order held at its start edge. A mode change during the burst takes effect only for bursts started after the mode-set edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_set | input | 1 | Mode-register load strobe |
| mode_addr | input | 13 | Address word carrying the mode fields |
| burst_start | input | 1 | Starts a burst at `start_col` |
| burst_is_read | input | 1 | 1 marks the burst being started as a read |
| start_col | input | 10 | Starting column of the burst |
| burst_stop | input | 1 | Ends the running burst |
| beat_valid | output | 1 | A column pair is being presented |
| last_beat | output | 1 | The current pair is the last of the burst |
| col_even | output | 10 | Column of beat 2i |
| col_odd | output | 10 | Column of beat 2i+1 |
| rd_valid | output | 1 | Read data window, latency-delayed |
| rd_half | output | 1 | Read window belongs to a latency-2.5 burst |
| mode_bl_len | output | 4 | Programmed burst length (2, 4 or 8) |
| mode_ilv | output | 1 | Programmed order, 1 = interleaved |
| mode_cl25 | output | 1 | Programmed latency is 2.5 |

## Verification
The bench builds the block with its default parameters: a 10-bit column, a 13-bit address word, a longest burst of 8 and two latency stages. With these values every burst length and both wrap orders are reached, including starting columns near the top of the column range where the upper bits must not change. Random mode words mix legal and reserved codes, and bursts are started, restarted and stopped at random points, so stops and restarts land on every beat position. Each output is compared every cycle with a bench model built from the requirements.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef struct packed {
        logic [1:0] bl_log;   // log2 of burst length: 1, 2 or 3
        logic       ilv;      // 1 = interleaved order
        logic       cl25;     // 1 = latency 2.5
    } mode_t;

    localparam mode_t MODE_RESET = '{bl_log: 2'd1, ilv: 1'b0, cl25: 1'b0};

    localparam logic [2:0] CL_CODE_2   = 3'b010;
    localparam logic [2:0] CL_CODE_2P5 = 3'b110;

endpackage

// File: rtl/mode_reg.sv
module mode_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_set,
    input  logic [ADDR_W-1:0] mode_addr,
    output mode_t             mode_o
);

    typedef struct packed {
        mode_t mode;
    } mreg_t;

    mreg_t st_d, st_q;

    logic [2:0] bl_field;
    logic [2:0] cl_field;
    logic       bl_legal;
    logic       cl_legal;

    always_comb begin
        bl_field = mode_addr[2:0];
        cl_field = mode_addr[6:4];
        bl_legal = (bl_field == 3'b001) || (bl_field == 3'b010) || (bl_field == 3'b011);
        cl_legal = (cl_field == CL_CODE_2) || (cl_field == CL_CODE_2P5);
        st_d = st_q;
        if (mode_set && bl_legal && cl_legal) begin
            st_d.mode.bl_log = bl_field[1:0];
            st_d.mode.ilv    = mode_addr[3];
            st_d.mode.cl25   = (cl_field == CL_CODE_2P5);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

endmodule

// File: rtl/col_gen.sv
module col_gen
    import burst_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int MAXLOG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             is_read,
    input  logic [COL_W-1:0] start_col,
    input  mode_t            mode,
    output logic             beat_valid,
    output logic             last_beat,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd,
    output logic             rd_beat,
    output logic             rd_half_src
);

    localparam int PAIR_W = (MAXLOG > 1) ? MAXLOG - 1 : 1;

    typedef struct packed {
        logic              active;
        logic              is_read;
        logic              ilv;
        logic              cl25;
        logic [1:0]        bl_log;
        logic [COL_W-1:0]  base;
        logic [PAIR_W-1:0] pair;
    } cg_t;

    cg_t st_d, st_q;

    logic [PAIR_W-1:0] pair_last;
    logic [MAXLOG-1:0] beat_e;
    logic [MAXLOG-1:0] beat_o;

    // Column of one beat: low bits wrap inside the burst, the rest stay put.
    function automatic logic [COL_W-1:0] beat_col(
        input logic [COL_W-1:0]  base,
        input logic [MAXLOG-1:0] beat,
        input logic [1:0]        bl_log,
        input logic              ilv
    );
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] low;
        mask = (COL_W'(1) << bl_log) - COL_W'(1);
        if (ilv) begin
            low = base ^ COL_W'(beat);
        end else begin
            low = base + COL_W'(beat);
        end
        return (base & ~mask) | (low & mask);
    endfunction

    always_comb begin
        pair_last = PAIR_W'((1 << (st_q.bl_log - 2'd1)) - 1);
        beat_e    = {st_q.pair, 1'b0};
        beat_o    = {st_q.pair, 1'b1};

        st_d = st_q;
        if (start) begin
            st_d.active  = 1'b1;
            st_d.is_read = is_read;
            st_d.ilv     = mode.ilv;
            st_d.cl25    = mode.cl25;
            st_d.bl_log  = mode.bl_log;
            st_d.base    = start_col;
            st_d.pair    = '0;
        end else if (stop) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (st_q.pair == pair_last) begin
                st_d.active = 1'b0;
            end else begin
                st_d.pair = st_q.pair + PAIR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active  <= 1'b0;
            st_q.is_read <= 1'b0;
            st_q.ilv     <= 1'b0;
            st_q.cl25    <= 1'b0;
            st_q.bl_log  <= 2'd1;
            st_q.base    <= '0;
            st_q.pair    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_valid  = st_q.active;
    assign last_beat   = st_q.active && (st_q.pair == pair_last);
    assign col_even    = beat_col(st_q.base, beat_e, st_q.bl_log, st_q.ilv);
    assign col_odd     = beat_col(st_q.base, beat_o, st_q.bl_log, st_q.ilv);
    assign rd_beat     = st_q.active && st_q.is_read;
    assign rd_half_src = st_q.cl25;

endmodule

// File: rtl/lat_pipe.sv
module lat_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_in,
    input  logic half_in,
    output logic vld_out,
    output logic half_out
);

    typedef struct packed {
        logic vld;
        logic half;
    } stage_t;

    stage_t [STAGES-1:0] pipe_d, pipe_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_comb begin
                if (s == 0) begin
                    pipe_d[s].vld  = vld_in;
                    pipe_d[s].half = vld_in && half_in;
                end else begin
                    pipe_d[s] = pipe_q[(s == 0) ? 0 : s - 1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q[s] <= '0;
                end else begin
                    pipe_q[s] <= pipe_d[s];
                end
            end
        end
    endgenerate

    assign vld_out  = pipe_q[STAGES-1].vld;
    assign half_out = pipe_q[STAGES-1].half;

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
    import burst_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int ADDR_W     = 13,
    parameter int MAXLOG     = 3,
    parameter int LAT_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_set,
    input  logic [ADDR_W-1:0] mode_addr,
    input  logic              burst_start,
    input  logic              burst_is_read,
    input  logic [COL_W-1:0]  start_col,
    input  logic              burst_stop,
    output logic              beat_valid,
    output logic              last_beat,
    output logic [COL_W-1:0]  col_even,
    output logic [COL_W-1:0]  col_odd,
    output logic              rd_valid,
    output logic              rd_half,
    output logic [3:0]        mode_bl_len,
    output logic              mode_ilv,
    output logic              mode_cl25
);

    mode_t cur_mode;
    logic  rd_beat;
    logic  rd_half_src;

    mode_reg #(.ADDR_W(ADDR_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_set  (mode_set),
        .mode_addr (mode_addr),
        .mode_o    (cur_mode)
    );

    col_gen #(.COL_W(COL_W), .MAXLOG(MAXLOG)) u_cols (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (burst_start),
        .stop        (burst_stop),
        .is_read     (burst_is_read),
        .start_col   (start_col),
        .mode        (cur_mode),
        .beat_valid  (beat_valid),
        .last_beat   (last_beat),
        .col_even    (col_even),
        .col_odd     (col_odd),
        .rd_beat     (rd_beat),
        .rd_half_src (rd_half_src)
    );

    lat_pipe #(.STAGES(LAT_STAGES)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_in   (rd_beat),
        .half_in  (rd_half_src),
        .vld_out  (rd_valid),
        .half_out (rd_half)
    );

    assign mode_bl_len = 4'(1 << cur_mode.bl_log);
    assign mode_ilv    = cur_mode.ilv;
    assign mode_cl25   = cur_mode.cl25;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_set,
    input logic [ADDR_W-1:0] mode_addr,
    input logic              burst_start,
    input logic              burst_stop,
    input logic              beat_valid,
    input logic              last_beat,
    input logic [COL_W-1:0]  col_even,
    input logic              rd_valid,
    input logic              rd_half,
    input logic [3:0]        mode_bl_len,
    input logic              mode_ilv,
    input logic              mode_cl25
);

    logic word_reserved;
    assign word_reserved = !(mode_addr[2:0] inside {3'b001, 3'b010, 3'b011}) ||
                           !(mode_addr[6:4] inside {3'b010, 3'b110});

    // R2: a word with a reserved code leaves the mode untouched
    p_reserved_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_set && word_reserved) |=> ($stable(mode_bl_len) && $stable(mode_ilv) && $stable(mode_cl25)));

    // R2: mode only changes on a mode-set edge
    p_mode_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_set |=> ($stable(mode_bl_len) && $stable(mode_ilv) && $stable(mode_cl25)));

    // R3: the last-beat flag only marks a live beat
    p_last_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> beat_valid);

    // R7: a start always yields a beat next cycle
    p_start_begins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> beat_valid);

    // R6: a stop without a start clears the burst
    p_stop_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !burst_start) |=> !beat_valid);

    // R5: upper column bits hold while the same burst continues
    p_upper_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !last_beat && !burst_start && !burst_stop) |=>
            (beat_valid && (col_even[COL_W-1:3] == $past(col_even[COL_W-1:3]))));

    // R9: the half-cycle flag only travels with read data
    p_half_with_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_half |-> rd_valid);

endmodule

bind burst_seq_top burst_seq_chk #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_set    (mode_set),
    .mode_addr   (mode_addr),
    .burst_start (burst_start),
    .burst_stop  (burst_stop),
    .beat_valid  (beat_valid),
    .last_beat   (last_beat),
    .col_even    (col_even),
    .rd_valid    (rd_valid),
    .rd_half     (rd_half),
    .mode_bl_len (mode_bl_len),
    .mode_ilv    (mode_ilv),
    .mode_cl25   (mode_cl25)
);

// File: tb/tb_burst_seq_top.sv
module tb_burst_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_set = 1'b0;
    logic [12:0] mode_addr = '0;
    logic        burst_start = 1'b0;
    logic        burst_is_read = 1'b0;
    logic [9:0]  start_col = '0;
    logic        burst_stop = 1'b0;
    logic        beat_valid, last_beat, rd_valid, rd_half, mode_ilv, mode_cl25;
    logic [9:0]  col_even, col_odd;
    logic [3:0]  mode_bl_len;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    burst_seq_top dut (.*);

    // Reference model, written from the requirements
    int   m_bl, m_ilv, m_cl25;
    bit   a_on, a_rd, a_ilv, a_half;
    int   a_bl, a_idx, a_base;
    bit   p1_v, p1_h, p2_v, p2_h;

    function automatic int exp_col(int base, int j, int bl, bit ilv);
        int low, hi;
        low = base % bl;
        hi  = base - low;
        return ilv ? hi + (low ^ j) : hi + ((low + j) % bl);
    endfunction

    function automatic bit legal_word(logic [12:0] w);
        return (w[2:0] inside {3'b001, 3'b010, 3'b011}) && (w[6:4] inside {3'b010, 3'b110});
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bl <= 2; m_ilv <= 0; m_cl25 <= 0;
            a_on <= 0; a_rd <= 0; a_ilv <= 0; a_half <= 0; a_bl <= 2; a_idx <= 0; a_base <= 0;
            p1_v <= 0; p1_h <= 0; p2_v <= 0; p2_h <= 0;
        end else begin
            p1_v <= a_on && a_rd;
            p1_h <= a_on && a_rd && a_half;
            p2_v <= p1_v;
            p2_h <= p1_h;
            if (burst_start) begin
                a_on <= 1; a_idx <= 0; a_base <= int'(start_col); a_rd <= burst_is_read;
                a_bl <= m_bl; a_ilv <= bit'(m_ilv); a_half <= bit'(m_cl25);
            end else if (burst_stop) begin
                a_on <= 0;
            end else if (a_on) begin
                if (a_idx == a_bl / 2 - 1) a_on <= 0;
                else a_idx <= a_idx + 1;
            end
            if (mode_set && legal_word(mode_addr)) begin
                m_bl   <= 1 << int'(mode_addr[1:0]);
                m_ilv  <= int'(mode_addr[3]);
                m_cl25 <= (mode_addr[6:4] == 3'b110) ? 1 : 0;
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    task automatic check_all(bit in_reset);
        string mreq;
        mreq = in_reset ? "R1" : "R2";
        chk(mreq, "mode_bl_len", int'(mode_bl_len), m_bl);
        chk(mreq, "mode_ilv", int'(mode_ilv), m_ilv);
        chk(mreq, "mode_cl25", int'(mode_cl25), m_cl25);
        chk(in_reset ? "R1" : "R3/R6/R7", "beat_valid", int'(beat_valid), int'(a_on));
        chk(in_reset ? "R1" : "R3", "last_beat", int'(last_beat), int'(a_on && a_idx == a_bl / 2 - 1));
        chk(in_reset ? "R1" : "R8", "rd_valid", int'(rd_valid), int'(p2_v));
        chk(in_reset ? "R1" : "R9", "rd_half", int'(rd_half), int'(p2_h));
        if (a_on) begin
            // R10: a_bl / a_ilv are the snapshot taken at start
            chk(a_ilv ? "R5/R10" : "R4/R10", "col_even", int'(col_even),
                exp_col(a_base, 2 * a_idx, a_bl, a_ilv));
            chk(a_ilv ? "R5/R10" : "R4/R10", "col_odd", int'(col_odd),
                exp_col(a_base, 2 * a_idx + 1, a_bl, a_ilv));
        end
    endtask

    // Apply one cycle of inputs, then check after the edge
    task automatic step(bit ms, logic [12:0] ma, bit bs, bit rd, logic [9:0] sc, bit sp);
        mode_set = ms; mode_addr = ma; burst_start = bs; burst_is_read = rd;
        start_col = sc; burst_stop = sp;
        @(negedge clk);
        cyc++;
        check_all(1'b0);
    endtask

    function automatic logic [12:0] mword(int bl_code, bit ilv, bit cl25);
        return {6'd0, cl25 ? 3'b110 : 3'b010, ilv, 3'(bl_code)};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check_all(1'b1);                     // R1 reset state
        rst_n = 1'b1;

        // R2: legal word BL8, interleaved, CL2.5
        step(1, mword(3, 1, 1), 0, 0, 0, 0);
        // R5: interleaved read from near the top of the column range
        step(0, 0, 1, 1, 10'h3FD, 0);
        repeat (6) step(0, 0, 0, 0, 0, 0);
        // R2: reserved length code ignored; then reserved latency code ignored
        step(1, 13'h0024, 0, 0, 0, 0);
        step(1, 13'h0032, 0, 0, 0, 0);
        // R4: sequential BL4 write with wrap from column 3
        step(1, mword(2, 0, 0), 0, 0, 0, 0);
        step(0, 0, 1, 0, 10'h203, 0);
        repeat (4) step(0, 0, 0, 0, 0, 0);
        // R6: stop in the middle of a BL8 read
        step(1, mword(3, 0, 0), 0, 0, 0, 0);
        step(0, 0, 1, 1, 10'h155, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1);
        repeat (4) step(0, 0, 0, 0, 0, 0);
        // R7: restart with stop on the same edge; R10: mode change mid-burst
        step(0, 0, 1, 1, 10'h010, 0);
        step(1, mword(1, 1, 1), 0, 0, 0, 0);
        step(0, 0, 1, 0, 10'h0F6, 1);
        repeat (5) step(0, 0, 0, 0, 0, 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            bit ms, bs, rd, sp;
            logic [12:0] ma;
            ms = ($urandom % 100) < 8;
            if ($urandom % 2) ma = mword(1 + ($urandom % 3), bit'($urandom % 2), bit'($urandom % 2));
            else ma = 13'($urandom);
            bs = ($urandom % 100) < 25;
            rd = bit'($urandom % 2);
            sp = ($urandom % 100) < 6;
            step(ms, ma, bs, rd, 10'($urandom), sp);
        end
        repeat (4) step(0, 0, 0, 0, 0, 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule